// File: doc/BRIEF.md
# Exception Ordering and Trace Sequencer

This block sits beside a processor's instruction-completion interface and decides, at every instruction boundary, which exceptions are taken and in which order. When an instruction retires it samples a small set of conditions: a forced exception raised by the instruction, a flag saying the instruction was illegal, unimplemented or privileged and so never executed, the trace bit of the status register, a pending breakpoint, a pending interrupt and a flag marking a stop-type instruction. From these it builds a queue and hands the exceptions out one at a time as single-cycle take pulses, each carrying a 3-bit code. It waits for a handler-done strobe before it issues the next one.

The block also owns the supervisor and trace bits of the status register. Each time an exception is entered it saves a copy of those bits, sets the supervisor bit and clears both trace bits. A stop-type instruction that completes with tracing off and nothing else pending puts the block into a stopped state. That state ends only when an interrupt arrives, and the interrupt is then taken. With tracing on, the instruction takes a trace exception instead of stopping.

Top module: `exc_trace_sequencer`

## Requirements
- R1: After reset take is 0, take_code is 0 (none), stopped and busy are 0, the status bits read supervisor 1 with both trace bits 0, and sr_copy is 0.
- R2: When an instruction completes with its forced-exception flag set while the trace bit (sr_t[1]) is 1, a take with code 1 (forced) comes before a take with code 2 (trace).
- R3: When an instruction completes with sr_t[1] set and an interrupt pending, code 2 (trace) is taken before code 4 (interrupt).
- R4: When several exceptions meet at one boundary, the codes are taken in the fixed order forced (1), trace (2), breakpoint (3), interrupt (4). Breakpoint and interrupt each follow trace.
- R5: An instruction flagged not-executed raises a forced exception (code 1) and never a trace exception, even when sr_t[1] is 1.
- R6: A stop-type instruction that completes with sr_t[1] set still loads the status value presented with it (sr_wr in the same cycle), then takes a trace exception whose saved copy is that loaded value. stopped stays 0. The trace decision uses the trace bit held before that load.
- R7: A stop-type instruction that executes with sr_t[1] clear and nothing else pending sets stopped (and busy) one cycle after the boundary. stopped stays set until irq_pend is seen. That clears stopped in the next cycle, and an interrupt take (code 4) follows in the cycle after that.
- R8: On every take, sr_copy equals {sr_s, sr_t} as it stood in the cycle before the take, and sr_s is 1 and sr_t is 0 in the cycle of the take.
- R9: A take is a single-cycle pulse. The first take appears in the second cycle after insn_done is sampled. Each following take appears in the second cycle after handler_done is sampled, and busy falls in the cycle after the last handler_done.
- R10: A boundary with sr_t[1] clear and no forced, not-executed, breakpoint, interrupt or stop condition produces no take and leaves busy at 0.
- R11: Trace bit sr_t[0] alone does not cause a trace exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | 1 | Instruction boundary strobe; only while busy is 0 |
| forced_exc | input | 1 | Completing instruction forces an exception |
| not_exec | input | 1 | Completing instruction was illegal, unimplemented or privileged |
| is_stop | input | 1 | Completing instruction is a stop-type instruction |
| bkpt_pend | input | 1 | Breakpoint pending at the boundary |
| irq_pend | input | 1 | Interrupt pending; held until its take |
| handler_done | input | 1 | Current exception handler finished |
| sr_wr | input | 1 | Write status bits this cycle |
| sr_wr_s | input | 1 | Supervisor bit to write |
| sr_wr_t | input | 2 | Trace bits to write, [1] traces every instruction |
| take | output | 1 | Exception-take pulse |
| take_code | output | 3 | 0 none, 1 forced, 2 trace, 3 breakpoint, 4 interrupt |
| stopped | output | 1 | Processor held in the stopped condition |
| busy | output | 1 | Exceptions queued or in service, or stopped |
| pend_kinds | output | 4 | Queued kinds: [0] forced, [1] trace, [2] breakpoint, [3] interrupt |
| sr_s | output | 1 | Current supervisor bit |
| sr_t | output | 2 | Current trace bits |
| sr_copy | output | 3 | Status copy saved at the last take, {s, t1, t0} |

## Verification
The assertions assume that insn_done arrives only while busy is low and that handler_done is given only after a take has been seen. They also assume the status-write port is not used in the cycle an exception is issued. The bench keeps to these assumptions by stepping through each boundary on falling edges. It raises handler_done only in the cycle after it has observed a take, and it writes the status bits only while the block is idle or alongside the stop-type boundary itself. Interrupt requests are held from the boundary until the whole queue has drained, which matches the rule that a request stays asserted until it is acknowledged.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int CODE_W = 3;
  localparam int KINDS  = 4;
  localparam int SR_W   = 3;
  localparam int T_W    = SR_W - 1;

  localparam int SLOT_FORCED = 0;
  localparam int SLOT_TRACE  = 1;
  localparam int SLOT_BKPT   = 2;
  localparam int SLOT_IRQ    = 3;

  typedef enum logic [CODE_W-1:0] {
    EXC_NONE   = 3'd0,
    EXC_FORCED = 3'd1,
    EXC_TRACE  = 3'd2,
    EXC_BKPT   = 3'd3,
    EXC_IRQ    = 3'd4
  } exc_code_e;

  typedef logic [KINDS-1:0] kind_mask_t;

  // code carried by a priority slot (lower slot index is taken first)
  function automatic exc_code_e slot_code(input int slot);
    exc_code_e c;
    case (slot)
      SLOT_FORCED: c = EXC_FORCED;
      SLOT_TRACE:  c = EXC_TRACE;
      SLOT_BKPT:   c = EXC_BKPT;
      SLOT_IRQ:    c = EXC_IRQ;
      default:     c = EXC_NONE;
    endcase
    return c;
  endfunction

  // one-hot of the highest-priority queued slot
  function automatic kind_mask_t lowest_slot(input kind_mask_t m);
    kind_mask_t r;
    r = '0;
    for (int i = KINDS - 1; i >= 0; i--) begin
      if (m[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  // code of a one-hot slot selection
  function automatic exc_code_e code_of(input kind_mask_t onehot);
    exc_code_e c;
    c = EXC_NONE;
    for (int i = 0; i < KINDS; i++) begin
      if (onehot[i]) c = slot_code(i);
    end
    return c;
  endfunction

  // slots that outrank a given code
  function automatic kind_mask_t ahead_of(input exc_code_e c);
    kind_mask_t r;
    logic hit;
    r   = '0;
    hit = 1'b0;
    for (int i = 0; i < KINDS; i++) begin
      if (slot_code(i) == c) hit = 1'b1;
      if (!hit) r[i] = 1'b1;
    end
    return r;
  endfunction

  // exceptions raised at one instruction boundary
  function automatic kind_mask_t boundary_kinds(input logic forced, input logic unexec,
                                                input logic trace_on, input logic bkpt,
                                                input logic irq);
    kind_mask_t m;
    m              = '0;
    m[SLOT_FORCED] = forced | unexec;
    m[SLOT_TRACE]  = trace_on & ~unexec;
    m[SLOT_BKPT]   = bkpt;
    m[SLOT_IRQ]    = irq;
    return m;
  endfunction

  // a stop-type instruction enters the stopped state only if nothing else fires
  function automatic logic stop_entry(input logic stop, input logic unexec,
                                      input logic trace_on, input kind_mask_t m);
    return stop & ~unexec & ~trace_on & (m == '0);
  endfunction

endpackage

// File: rtl/exc_capture.sv
module exc_capture
  import exc_seq_pkg::*;
(
  input  logic       forced_exc,
  input  logic       not_exec,
  input  logic       is_stop,
  input  logic       bkpt_pend,
  input  logic       irq_pend,
  input  logic       trace_on,
  output kind_mask_t kinds,
  output logic       stop_req
);

  kind_mask_t raw_kinds;

  always_comb begin
    raw_kinds = boundary_kinds(forced_exc, not_exec, trace_on, bkpt_pend, irq_pend);
  end

  assign kinds    = raw_kinds;
  assign stop_req = stop_entry(is_stop, not_exec, trace_on, raw_kinds);

endmodule

// File: rtl/exc_issue.sv
module exc_issue
  import exc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insn_done,
  input  kind_mask_t cap_kinds,
  input  logic       stop_req,
  input  logic       irq_pend,
  input  logic       handler_done,
  output logic       issue_fire,
  output logic       take,
  output exc_code_e  take_code,
  output logic       stopped,
  output logic       busy,
  output kind_mask_t pend_kinds
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e        state;
  kind_mask_t pend_q;
  kind_mask_t pick;
  logic       boundary_accept;
  logic       wake_accept;
  logic       wait_release;
  kind_mask_t irq_only;

  always_comb begin
    irq_only           = '0;
    irq_only[SLOT_IRQ] = 1'b1;
  end

  assign pick            = lowest_slot(pend_q);
  assign issue_fire      = (state == ST_ISSUE);
  assign boundary_accept = (state == ST_IDLE) && insn_done;
  assign wake_accept     = (state == ST_IDLE) && !insn_done && stopped && irq_pend;
  assign wait_release    = (state == ST_WAIT) && handler_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend_q    <= '0;
      take      <= 1'b0;
      take_code <= EXC_NONE;
      stopped   <= 1'b0;
    end else begin
      take      <= 1'b0;
      take_code <= EXC_NONE;
      case (state)
        ST_IDLE: begin
          if (boundary_accept) begin
            if (cap_kinds != '0) begin
              pend_q <= cap_kinds;
              state  <= ST_ISSUE;
            end else if (stop_req) begin
              stopped <= 1'b1;
            end
          end else if (wake_accept) begin
            pend_q  <= irq_only;
            stopped <= 1'b0;
            state   <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          take      <= 1'b1;
          take_code <= code_of(pick);
          pend_q    <= pend_q & ~pick;
          state     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wait_release) state <= (pend_q != '0) ? ST_ISSUE : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE) || stopped;
  assign pend_kinds = pend_q;

  // R9: a take lasts one cycle
  assert_take_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  // R9: code is meaningful exactly while take is high
  assert_take_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_code != EXC_NONE));

  assert_idle_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (take_code == EXC_NONE));

  // R9: boundaries arrive only while idle (input rule)
  assert_boundary_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done |-> !busy);

  // R7: leaving the stopped state is followed by an interrupt take
  assert_wake_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stopped) |=> (take && take_code == EXC_IRQ));

  // R4: nothing still queued outranks the code just taken
  assert_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((pend_q & ahead_of(take_code)) == '0));

endmodule

// File: rtl/exc_status.sv
module exc_status
  import exc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter,
  input  logic            sr_wr,
  input  logic [SR_W-1:0] sr_wr_val,
  output logic [SR_W-1:0] sr_val,
  output logic [SR_W-1:0] sr_copy
);

  localparam logic [SR_W-1:0] SR_RESET = {1'b1, {T_W{1'b0}}};
  localparam logic [SR_W-1:0] SR_ENTER = {1'b1, {T_W{1'b0}}};

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] copy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= SR_RESET;
      copy_q <= '0;
    end else if (enter) begin
      copy_q <= sr_q;
      sr_q   <= SR_ENTER;
    end else if (sr_wr) begin
      sr_q <= sr_wr_val;
    end
  end

  assign sr_val  = sr_q;
  assign sr_copy = copy_q;

  // R8: status is not written by software in an entry cycle (input rule)
  assert_no_wr_on_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enter |-> !sr_wr);

endmodule

// File: rtl/exc_trace_sequencer.sv
module exc_trace_sequencer
  import exc_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 insn_done,
  input  logic                 forced_exc,
  input  logic                 not_exec,
  input  logic                 is_stop,
  input  logic                 bkpt_pend,
  input  logic                 irq_pend,
  input  logic                 handler_done,
  input  logic                 sr_wr,
  input  logic                 sr_wr_s,
  input  logic [T_W-1:0]       sr_wr_t,
  output logic                 take,
  output logic [CODE_W-1:0]    take_code,
  output logic                 stopped,
  output logic                 busy,
  output logic [KINDS-1:0]     pend_kinds,
  output logic                 sr_s,
  output logic [T_W-1:0]       sr_t,
  output logic [SR_W-1:0]      sr_copy
);

  kind_mask_t      cap_kinds;
  kind_mask_t      pend_q;
  logic            stop_req;
  logic            issue_fire;
  logic            trace_on;
  exc_code_e       code_q;
  logic [SR_W-1:0] sr_val;

  assign trace_on = sr_val[T_W-1];

  exc_capture u_capture (
    .forced_exc (forced_exc),
    .not_exec   (not_exec),
    .is_stop    (is_stop),
    .bkpt_pend  (bkpt_pend),
    .irq_pend   (irq_pend),
    .trace_on   (trace_on),
    .kinds      (cap_kinds),
    .stop_req   (stop_req)
  );

  exc_issue u_issue (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_done    (insn_done),
    .cap_kinds    (cap_kinds),
    .stop_req     (stop_req),
    .irq_pend     (irq_pend),
    .handler_done (handler_done),
    .issue_fire   (issue_fire),
    .take         (take),
    .take_code    (code_q),
    .stopped      (stopped),
    .busy         (busy),
    .pend_kinds   (pend_q)
  );

  exc_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter     (issue_fire),
    .sr_wr     (sr_wr),
    .sr_wr_val ({sr_wr_s, sr_wr_t}),
    .sr_val    (sr_val),
    .sr_copy   (sr_copy)
  );

  assign take_code  = code_q;
  assign pend_kinds = pend_q;
  assign sr_s       = sr_val[SR_W-1];
  assign sr_t       = sr_val[T_W-1:0];

  // R8: entry saves the prior status and leaves supervisor set, trace clear
  assert_entry_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (sr_s && sr_t == '0 && sr_copy == $past(sr_val)));

  // R5: a non-executed instruction never queues a trace
  assert_no_trace_unexec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && not_exec) |=> !pend_q[SLOT_TRACE]);

  // R6: tracing overrides entry into the stopped state
  assert_stop_traced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && is_stop && trace_on && !not_exec) |=> (!stopped && busy));

  // R11: the second trace bit alone queues no trace
  assert_t0_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !trace_on && !busy) |=> !pend_q[SLOT_TRACE]);

endmodule

// File: tb/tb_exc_trace_sequencer.sv
module tb_exc_trace_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       insn_done = 0, forced_exc = 0, not_exec = 0, is_stop = 0;
  logic       bkpt_pend = 0, irq_pend = 0, handler_done = 0;
  logic       sr_wr = 0, sr_wr_s = 0;
  logic [1:0] sr_wr_t = 0;
  logic       take, stopped, busy, sr_s;
  logic [2:0] take_code, sr_copy;
  logic [3:0] pend_kinds;
  logic [1:0] sr_t;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  exc_trace_sequencer dut (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .forced_exc(forced_exc),
    .not_exec(not_exec), .is_stop(is_stop), .bkpt_pend(bkpt_pend),
    .irq_pend(irq_pend), .handler_done(handler_done), .sr_wr(sr_wr),
    .sr_wr_s(sr_wr_s), .sr_wr_t(sr_wr_t), .take(take), .take_code(take_code),
    .stopped(stopped), .busy(busy), .pend_kinds(pend_kinds), .sr_s(sr_s),
    .sr_t(sr_t), .sr_copy(sr_copy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_val(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // one boundary; the expected order is built from the requirements
  task automatic run_case(input bit f, input bit ne, input bit st, input bit bk,
                          input bit irq, input bit t1, input bit t0);
    int exp_codes[4];
    int n = 0;
    bit stop_exp;
    int first_copy;
    if (f || ne) begin exp_codes[n] = 1; n++; end
    if (t1 && !ne) begin exp_codes[n] = 2; n++; end
    if (bk) begin exp_codes[n] = 3; n++; end
    if (irq) begin exp_codes[n] = 4; n++; end
    stop_exp = st && !ne && !t1 && (n == 0);
    first_copy = st ? 3'b001 : {1'b0, t1, t0};

    @(negedge clk);
    sr_wr = 1; sr_wr_s = 0; sr_wr_t = {t1, t0};
    @(negedge clk);
    sr_wr = 0;
    insn_done = 1; forced_exc = f; not_exec = ne; is_stop = st;
    bkpt_pend = bk; irq_pend = irq;
    if (st) begin
      sr_wr = 1; sr_wr_s = 0; sr_wr_t = 2'b01;
    end
    @(negedge clk);
    insn_done = 0; forced_exc = 0; not_exec = 0; is_stop = 0;
    bkpt_pend = 0; sr_wr = 0;
    expect_val("R9 no take in first cycle", take, 0);
    if (st) begin
      expect_val("R6 R7 stopped after stop-type", stopped, stop_exp);
      expect_val("R6 stop loads status bits", {sr_s, sr_t}, 3'b001);
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      expect_val("R2 R3 R4 R5 take present", take, 1);
      expect_val("R2 R3 R4 R5 take order", take_code, exp_codes[k]);
      expect_val("R8 supervisor on entry", sr_s, 1);
      expect_val("R8 trace cleared on entry", sr_t, 0);
      expect_val("R8 saved copy", sr_copy, (k == 0) ? first_copy : 3'b100);
      handler_done = 1;
      @(negedge clk);
      handler_done = 0;
      expect_val("R9 single-cycle take", take, 0);
      if (k == n - 1) expect_val("R9 busy falls after last", busy, 0);
      else expect_val("R9 busy while queued", busy, 1);
    end
    if (n == 0 && !stop_exp) begin
      @(negedge clk);
      expect_val("R10 no take", take, 0);
      expect_val("R10 not busy", busy, 0);
    end
    if (stop_exp) begin
      expect_val("R7 busy while stopped", busy, 1);
      @(negedge clk);
      @(negedge clk);
      expect_val("R7 still stopped", stopped, 1);
      expect_val("R7 no take while stopped", take, 0);
      irq_pend = 1;
      @(negedge clk);
      expect_val("R7 stopped clears on interrupt", stopped, 0);
      expect_val("R7 take not yet", take, 0);
      @(negedge clk);
      expect_val("R7 interrupt take", take, 1);
      expect_val("R7 interrupt code", take_code, 4);
      expect_val("R8 copy at wake", sr_copy, 3'b001);
      handler_done = 1;
      @(negedge clk);
      handler_done = 0;
      expect_val("R7 idle after wake", busy, 0);
    end
    irq_pend = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_val("R1 take", take, 0);
    expect_val("R1 code", take_code, 0);
    expect_val("R1 stopped", stopped, 0);
    expect_val("R1 busy", busy, 0);
    expect_val("R1 status", {sr_s, sr_t}, 3'b100);
    expect_val("R1 copy", sr_copy, 0);

    // R11: only the second trace bit set, nothing else pending
    run_case(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    expect_val("R11 no trace from t0", take, 0);

    for (int v = 0; v < 64; v++) begin
      run_case(v[0], v[1], v[2], v[3], v[4], v[5], v[0] ^ v[3]);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule